// File: doc/BRIEF.md
# Grouped Interrupt Level Controller

This block holds the per-level control state for a bank of prioritised interrupt levels, organised as groups of sixteen. Every level carries an armed flag, an enabled flag and a three-way condition (idle, waiting, active). Software-style control writes name one group, give a function code and a sixteen-bit selection mask. Each level picked by a 1 in the mask is changed as the code says, and every other level keeps its state.

Hardware sources pulse a per-level trigger that moves an armed, idle level to waiting. The block raises a request whenever some waiting, enabled level outranks every active level. An acknowledge makes that level active. A separate strobe ends the highest-ranked active level and returns it to idle. Priority follows the flat level number `group*16 + k`, so the lowest number ranks highest: group 0, level 0 is the top level.

Top module: `intr_group_ctrl`

## Requirements
- R1: After reset every level is disarmed, disabled and idle, and `req` is low.
- R2: A write with `wr_valid` high touches only the levels of group `wr_group` whose mask bit is 1. Mask bit k selects level k of the group, which is flat level `wr_group*16 + k`. Levels not selected keep their armed, enabled and condition state.
- R3: Function code 3'b001 disarms the selected levels and returns them to idle. Their enabled flag is unchanged.
- R4: Function code 3'b010 arms and enables the selected levels and returns them to idle.
- R5: Function code 3'b011 arms and disables the selected levels and returns them to idle.
- R6: Function code 3'b100 enables the selected levels and code 3'b101 disables them. Neither code changes the armed flag or the condition.
- R7: A write with code 3'b000, 3'b110 or 3'b111, or one that names a group number at or above `NUM_GROUPS`, changes no state.
- R8: A trigger pulse on an armed, idle level makes it waiting on the next cycle. A trigger on a disarmed level, or on a level that is already waiting or active, has no effect.
- R9: `req` is high exactly when the lowest-numbered waiting, enabled level has a lower flat number than every active level. `req_group` and `req_index` then name that level.
- R10: `ack` while `req` is high makes the requesting level active on the next cycle. `ack` while `req` is low changes nothing.
- R11: `clr_act` returns the lowest-numbered active level to idle on the next cycle. With no level active it has no effect.
- R12: If a write with code 001, 010 or 011 selects a level in the same cycle as a trigger, acknowledge or clear acts on that level, the write wins and the level ends idle. Codes 100 and 101 do not block a trigger in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Control write strobe |
| wr_group | input | 4 | Group number of the write |
| wr_func | input | 3 | Function code of the write |
| wr_mask | input | 16 | Level selection mask, bit k selects level k |
| trig | input | NUM_GROUPS*16 | Per-level trigger pulses, flat numbering |
| ack | input | 1 | Acknowledge the current request |
| clr_act | input | 1 | End the highest-ranked active level |
| req | output | 1 | A waiting, enabled level outranks all active levels |
| req_group | output | 4 | Group of the requesting level |
| req_index | output | 4 | Index within the group of the requesting level |
| lvl_armed | output | NUM_GROUPS*16 | Armed flag of every level |
| lvl_enabled | output | NUM_GROUPS*16 | Enabled flag of every level |
| lvl_waiting | output | NUM_GROUPS*16 | Level is waiting |
| lvl_active | output | NUM_GROUPS*16 | Level is active |

## Verification
The risky collision is a clearing control write (codes 001 to 011) landing on a level in the same cycle as a trigger, an acknowledge or an end-of-service strobe aimed at that level. The directed part sets this up on purpose: a level is acknowledged while a disarm write selects it, and enable or disable writes are issued alongside triggers. The random part mixes all strobes on every cycle, so such overlaps recur. A bench model applies the write last and the other actions before it. Every level's four state bits and the request outputs are compared with that model each cycle.

// File: rtl/igc_pkg.sv
package igc_pkg;

   localparam int GRP_LEVELS = 16;
   localparam int FUNC_W     = 3;

   typedef enum logic [1:0] {
      LS_IDLE = 2'b00,
      LS_WAIT = 2'b01,
      LS_ACT  = 2'b10
   } lvl_state_e;

   typedef struct packed {
      logic arm_set;
      logic arm_clr;
      logic en_set;
      logic en_clr;
      logic st_clr;
   } lvl_op_t;

   function automatic lvl_op_t decode_func(input logic [FUNC_W-1:0] f);
      lvl_op_t o;
      o = '0;
      case (f)
         3'b001: begin o.arm_clr = 1'b1; o.st_clr = 1'b1; end
         3'b010: begin o.arm_set = 1'b1; o.en_set = 1'b1; o.st_clr = 1'b1; end
         3'b011: begin o.arm_set = 1'b1; o.en_clr = 1'b1; o.st_clr = 1'b1; end
         3'b100: o.en_set = 1'b1;
         3'b101: o.en_clr = 1'b1;
         default: o = '0;
      endcase
      return o;
   endfunction

endpackage

// File: rtl/igc_wr_decode.sv
module igc_wr_decode
   import igc_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int GID_W      = 4,
   localparam int NLVL      = NUM_GROUPS * GRP_LEVELS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_valid,
   input  logic [GID_W-1:0]      wr_group,
   input  logic [FUNC_W-1:0]     wr_func,
   input  logic [GRP_LEVELS-1:0] wr_mask,
   output logic [NLVL-1:0]       sel,
   output lvl_op_t               op
);

   generate
      if (NUM_GROUPS > (1 << GID_W)) begin : g_bad_gid
         $error("igc_wr_decode: GID_W too narrow for NUM_GROUPS");
      end
   endgenerate

   assign op = decode_func(wr_func);

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic hit;
      assign hit = wr_valid && (wr_group == GID_W'(g));
      assign sel[g*GRP_LEVELS +: GRP_LEVELS] = hit ? wr_mask : '0;
   end

   // R7
   no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && ((wr_func == 3'b000) || (wr_func == 3'b110) || (wr_func == 3'b111)))
      |-> (op == '0));

   // R7
   bad_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_group >= GID_W'(NUM_GROUPS)) |-> (sel == '0));

endmodule

// File: rtl/igc_level_cell.sv
module igc_level_cell
   import igc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  lvl_op_t    op,
   input  logic       trig,
   input  logic       ack_hit,
   input  logic       clr_hit,
   output logic       armed,
   output logic       enabled,
   output lvl_state_e state
);

   logic       arm_q, en_q, arm_d, en_d;
   lvl_state_e st_q, st_d;

   always_comb begin
      arm_d = arm_q;
      en_d  = en_q;
      st_d  = st_q;
      if (clr_hit) st_d = LS_IDLE;
      if (ack_hit) st_d = LS_ACT;
      if (trig && arm_q && (st_q == LS_IDLE)) st_d = LS_WAIT;
      if (sel) begin
         if (op.arm_set) arm_d = 1'b1;
         if (op.arm_clr) arm_d = 1'b0;
         if (op.en_set)  en_d  = 1'b1;
         if (op.en_clr)  en_d  = 1'b0;
         if (op.st_clr)  st_d  = LS_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
         en_q  <= 1'b0;
         st_q  <= LS_IDLE;
      end else begin
         arm_q <= arm_d;
         en_q  <= en_d;
         st_q  <= st_d;
      end
   end

   assign armed   = arm_q;
   assign enabled = en_q;
   assign state   = st_q;

   // R2
   unsel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> ($stable(armed) && $stable(enabled)));

   // R12
   wr_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && op.st_clr) |=> (state == LS_IDLE));

   // R8
   disarmed_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && (state == LS_IDLE)) |=> (state == LS_IDLE));

   // R10
   ack_only_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit |-> (state == LS_WAIT));

endmodule

// File: rtl/igc_find_first.sv
module igc_find_first #(
   parameter int N  = 64,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

   assign found = |vec;

endmodule

// File: rtl/intr_group_ctrl.sv
module intr_group_ctrl
   import igc_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int GID_W      = 4,
   localparam int NLVL      = NUM_GROUPS * GRP_LEVELS,
   localparam int IW        = $clog2(NLVL),
   localparam int LIW       = $clog2(GRP_LEVELS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_valid,
   input  logic [GID_W-1:0]      wr_group,
   input  logic [FUNC_W-1:0]     wr_func,
   input  logic [GRP_LEVELS-1:0] wr_mask,
   input  logic [NLVL-1:0]       trig,
   input  logic                  ack,
   input  logic                  clr_act,
   output logic                  req,
   output logic [GID_W-1:0]      req_group,
   output logic [LIW-1:0]        req_index,
   output logic [NLVL-1:0]       lvl_armed,
   output logic [NLVL-1:0]       lvl_enabled,
   output logic [NLVL-1:0]       lvl_waiting,
   output logic [NLVL-1:0]       lvl_active
);

   generate
      if (NUM_GROUPS < 1) begin : g_bad_ng
         $error("intr_group_ctrl: NUM_GROUPS must be at least 1");
      end
      if ((IW - LIW) > GID_W) begin : g_bad_gw
         $error("intr_group_ctrl: GID_W cannot hold the group number");
      end
   endgenerate

   logic [NLVL-1:0] sel;
   lvl_op_t         op;
   logic [NLVL-1:0] cand;
   logic [NLVL-1:0] ack_hit, clr_hit;
   logic            w_found, a_found, ack_fire;
   logic [IW-1:0]   w_idx, a_idx;

   igc_wr_decode #(
      .NUM_GROUPS(NUM_GROUPS),
      .GID_W     (GID_W)
   ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_valid(wr_valid),
      .wr_group(wr_group),
      .wr_func (wr_func),
      .wr_mask (wr_mask),
      .sel     (sel),
      .op      (op)
   );

   for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      lvl_state_e st;
      igc_level_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .sel    (sel[l]),
         .op     (op),
         .trig   (trig[l]),
         .ack_hit(ack_hit[l]),
         .clr_hit(clr_hit[l]),
         .armed  (lvl_armed[l]),
         .enabled(lvl_enabled[l]),
         .state  (st)
      );
      assign lvl_waiting[l] = (st == LS_WAIT);
      assign lvl_active[l]  = (st == LS_ACT);
      assign ack_hit[l]     = ack_fire && (w_idx == IW'(l));
      assign clr_hit[l]     = clr_act && a_found && (a_idx == IW'(l));
   end

   assign cand = lvl_waiting & lvl_enabled;

   igc_find_first #(.N(NLVL), .IW(IW)) u_pick_wait (
      .vec  (cand),
      .found(w_found),
      .idx  (w_idx)
   );

   igc_find_first #(.N(NLVL), .IW(IW)) u_pick_act (
      .vec  (lvl_active),
      .found(a_found),
      .idx  (a_idx)
   );

   assign req      = w_found && (!a_found || (w_idx < a_idx));
   assign ack_fire = ack && req;

   assign req_index = w_idx[LIW-1:0];
   generate
      if (IW > LIW) begin : g_multi_grp
         assign req_group = GID_W'(w_idx[IW-1:LIW]);
      end else begin : g_one_grp
         assign req_group = '0;
      end
   endgenerate

   // R9
   req_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (lvl_waiting[w_idx] && lvl_enabled[w_idx]));

   // R10
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_hit));

   // R10
   ack_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && req && !wr_valid) |=> lvl_active[$past(w_idx)]);

   // R11
   clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_hit));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (lvl_armed == '0 && lvl_active == '0));

endmodule

// File: tb/intr_group_ctrl_tb_top.sv
`timescale 1ns/100ps
module intr_group_ctrl_tb_top;

   localparam int NG  = 4;
   localparam int NL  = NG * 16;
   localparam int RND_CYCLES = 4000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [3:0]    wr_group = '0;
   logic [2:0]    wr_func = '0;
   logic [15:0]   wr_mask = '0;
   logic [NL-1:0] trig = '0;
   logic          ack = 1'b0;
   logic          clr_act = 1'b0;
   logic          req;
   logic [3:0]    req_group;
   logic [3:0]    req_index;
   logic [NL-1:0] lvl_armed, lvl_enabled, lvl_waiting, lvl_active;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit [NL-1:0] m_arm, m_en, m_wait, m_act;

   always #2.5 clk = ~clk;

   intr_group_ctrl #(.NUM_GROUPS(NG), .GID_W(4)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_group(wr_group), .wr_func(wr_func), .wr_mask(wr_mask),
      .trig(trig), .ack(ack), .clr_act(clr_act),
      .req(req), .req_group(req_group), .req_index(req_index),
      .lvl_armed(lvl_armed), .lvl_enabled(lvl_enabled),
      .lvl_waiting(lvl_waiting), .lvl_active(lvl_active)
   );

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic void pick(input bit [NL-1:0] v, output int idx, output bit found);
      found = 1'b0;
      idx = 0;
      for (int i = 0; i < NL; i++) begin
         if (v[i] && !found) begin found = 1'b1; idx = i; end
      end
   endfunction

   task automatic set_idle();
      wr_valid = 1'b0; wr_group = '0; wr_func = '0; wr_mask = '0;
      trig = '0; ack = 1'b0; clr_act = 1'b0;
   endtask

   task automatic step(input string tag);
      int wi, ai;
      bit wf, af, mreq;
      bit [NL-1:0] n_arm, n_en, n_wait, n_act;
      #1;
      pick(m_wait & m_en, wi, wf);
      pick(m_act, ai, af);
      mreq = wf && (!af || wi < ai);
      chk(tag, "req", 64'(req), 64'(mreq));
      if (mreq) begin
         chk(tag, "req_group", 64'(req_group), 64'(wi / 16));
         chk(tag, "req_index", 64'(req_index), 64'(wi % 16));
      end
      n_arm = m_arm; n_en = m_en; n_wait = m_wait; n_act = m_act;
      if (clr_act && af) n_act[ai] = 1'b0;
      if (ack && mreq) begin n_wait[wi] = 1'b0; n_act[wi] = 1'b1; end
      for (int l = 0; l < NL; l++) begin
         if (trig[l] && m_arm[l] && !m_wait[l] && !m_act[l]) n_wait[l] = 1'b1;
         if (wr_valid && wr_group < NG && int'(wr_group) == l / 16 && wr_mask[l % 16]) begin
            case (wr_func)
               3'b001: begin n_arm[l] = 0; n_wait[l] = 0; n_act[l] = 0; end
               3'b010: begin n_arm[l] = 1; n_en[l] = 1; n_wait[l] = 0; n_act[l] = 0; end
               3'b011: begin n_arm[l] = 1; n_en[l] = 0; n_wait[l] = 0; n_act[l] = 0; end
               3'b100: n_en[l] = 1;
               3'b101: n_en[l] = 0;
               default: ;
            endcase
         end
      end
      m_arm = n_arm; m_en = n_en; m_wait = n_wait; m_act = n_act;
      @(posedge clk);
      #1;
      chk(tag, "armed",   lvl_armed,   m_arm);
      chk(tag, "enabled", lvl_enabled, m_en);
      chk(tag, "waiting", lvl_waiting, m_wait);
      chk(tag, "active",  lvl_active,  m_act);
      set_idle();
   endtask

   task automatic wr(input logic [3:0] g, input logic [2:0] f, input logic [15:0] m);
      wr_valid = 1'b1; wr_group = g; wr_func = f; wr_mask = m;
   endtask

   initial begin
      #(5ns * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      m_arm = '0; m_en = '0; m_wait = '0; m_act = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      chk("R1", "armed", lvl_armed, '0);
      chk("R1", "enabled", lvl_enabled, '0);
      chk("R1", "waiting|active", lvl_waiting | lvl_active, '0);
      chk("R1", "req", 64'(req), 64'(0));

      wr(4'd1, 3'b010, 16'h8001);                 step("R4");
      trig = '0; trig[16] = 1; trig[31] = 1; trig[0] = 1;  step("R8");   // level 0 disarmed
      trig[16] = 1;                                step("R8");          // already waiting
      step("R9");
      ack = 1'b1;                                  step("R10");
      ack = 1'b1;                                  step("R10");         // 31 below active 16
      wr(4'd1, 3'b101, 16'h8000);                  step("R6");
      wr(4'd1, 3'b100, 16'h8000);                  step("R6");
      clr_act = 1'b1;                              step("R11");
      step("R9");
      ack = 1'b1; wr(4'd1, 3'b001, 16'h8000);      step("R12");
      clr_act = 1'b1;                              step("R11");         // none active
      wr(4'd1, 3'b000, 16'hFFFF);                  step("R7");
      wr(4'd1, 3'b110, 16'hFFFF);                  step("R7");
      wr(4'd1, 3'b111, 16'hFFFF);                  step("R7");
      wr(4'd5, 3'b010, 16'hFFFF);                  step("R7");
      wr(4'd2, 3'b011, 16'h00F0);                  step("R5");
      trig[39:36] = 4'hF; wr(4'd2, 3'b100, 16'h0040); step("R12");
      wr(4'd2, 3'b001, 16'h0030);                  step("R3");
      wr(4'd0, 3'b010, 16'h0001);                  step("R2");
      trig[0] = 1; trig[38] = 1;                   step("R8");
      ack = 1'b1;                                  step("R10");

      for (int c = 0; c < RND_CYCLES; c++) begin
         if ($urandom_range(99) < 30) begin
            wr(4'($urandom_range(5)), 3'($urandom_range(7)), 16'($urandom & $urandom));
         end
         trig = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         ack = ($urandom_range(99) < 35);
         clr_act = ($urandom_range(99) < 20);
         step("R2");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule